// File: doc/BRIEF.md
# Sparse Hit Readout Priority Encoder

This block reads out the pixels of one group that were hit during a time slot. It takes a request vector with one bit per pixel. On a time-slot boundary it copies that vector into a service set. A binary OR tree over the service set reports whether any hit is still waiting. At every node the tree gives priority to the lower branch if that branch has a request. The winning path spells out the binary address of the highest-priority pixel, one address bit per tree level.

Each readout-step strobe serves the presented pixel. The block returns a one-hot acknowledge to that pixel one cycle later and removes it from the service set, so the next pending pixel is presented. Requests that appear between boundaries wait for the next boundary, so hits being collected never mix with the slot being read out.

A two-state controller tracks whether the service set holds work:
- ST_IDLE means the set is empty. It moves to ST_SERVE on a boundary with at least one request.
- ST_SERVE means readout is in progress. It returns to ST_IDLE when a strobe serves the last pixel, or when a boundary captures an empty vector.
- A boundary while in ST_SERVE with requests present stays in ST_SERVE.

Top module: `pixq_encoder`

## Requirements
- R1: `any_hit` is 1 exactly when the service set holds at least one pixel.
- R2: `addr` gives the lowest index in the service set. It is 0 when the set is empty, so pixel 0 is told apart from an empty group only by `any_hit`.
- R3: The service set is loaded from `req` only in a cycle with `slot_tick` high. A change of `req` at any other time does not affect `any_hit`, `addr` or `ack`.
- R4: A `step` with no `slot_tick` while the set is non-empty makes `ack` one-hot at the served index in the next cycle. In that same cycle the pixel leaves the set and `addr` moves to the next higher pending index, or reads 0 if the set is now empty.
- R5: `ack` is all zeros in every cycle that does not follow a served step. A `step` while the set is empty has no effect.
- R6: When `slot_tick` and `step` are high in the same cycle, the boundary wins. The set is replaced by `req`, no pixel is served, and `ack` stays all zeros.
- R7: While `rst_n` is low, and right after reset, the set is empty, `any_hit` is 0, `addr` is 0 and `ack` is all zeros.
- R8: With neither `step` nor `slot_tick` high, `addr` and `any_hit` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPIX (256) | Per-pixel hit requests |
| slot_tick | input | 1 | Time-slot boundary, loads the service set |
| step | input | 1 | Readout-step strobe, serves the presented pixel |
| any_hit | output | 1 | OR of the service set |
| addr | output | AW (8) | Address of the presented pixel, 0 when empty |
| ack | output | NPIX (256) | One-hot acknowledge to the served pixel |

## Verification
A time-slot boundary and a readout step can land in the same cycle, and each of them wants to rewrite the service set. The bench provokes this by raising `slot_tick` and `step` together while pixels 7 and 20 are pending, with a fresh request vector holding pixels 1 and 30. It then expects `ack` to stay all zeros, `addr` to read 1 and a later step to acknowledge pixel 1. That shows the new slot replaced the old set and nothing from the old set was served.

// File: rtl/pixq_pkg.sv
`timescale 1ns/1ps
package pixq_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } pixq_state_t;
endpackage

// File: rtl/pixq_tree.sv
`timescale 1ns/1ps
// OR tree with lower-branch priority; address bits are formed one level at a time.
module pixq_tree #(
    parameter int N  = 256,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  leaves,
    output logic          any,
    output logic [AW-1:0] idx
);
    logic          nany [AW+1][N];
    logic [AW-1:0] nidx [AW+1][N];

    for (genvar k = 0; k < N; k++) begin : g_leaf
        assign nany[0][k] = leaves[k];
        assign nidx[0][k] = '0;
    end

    for (genvar l = 0; l < AW; l++) begin : g_lvl
        for (genvar k = 0; k < (N >> (l + 1)); k++) begin : g_node
            assign nany[l+1][k] = nany[l][2*k] | nany[l][2*k+1];
            assign nidx[l+1][k] = nany[l][2*k] ? nidx[l][2*k]
                                               : (nidx[l][2*k+1] | AW'(1 << l));
        end
    end

    assign any = nany[AW][0];
    assign idx = nany[AW][0] ? nidx[AW][0] : '0;
endmodule

// File: rtl/pixq_onehot.sv
`timescale 1ns/1ps
module pixq_onehot #(
    parameter int N  = 256,
    parameter int AW = $clog2(N)
) (
    input  logic          en,
    input  logic [AW-1:0] idx,
    output logic [N-1:0]  oh
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign oh[i] = en && (idx == AW'(i));
    end
endmodule

// File: rtl/pixq_encoder.sv
`timescale 1ns/1ps
module pixq_encoder
    import pixq_pkg::*;
#(
    parameter int NPIX = 256,
    parameter int AW   = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIX-1:0] req,
    input  logic            slot_tick,
    input  logic            step,
    output logic            any_hit,
    output logic [AW-1:0]   addr,
    output logic [NPIX-1:0] ack
);
    pixq_state_t     state_q, state_d;
    logic [NPIX-1:0] svc_q;
    logic [NPIX-1:0] ack_q;
    logic [NPIX-1:0] grant_oh;
    logic            served;
    logic            last_one;

    pixq_tree #(.N(NPIX), .AW(AW)) u_tree (
        .leaves (svc_q),
        .any    (any_hit),
        .idx    (addr)
    );

    pixq_onehot #(.N(NPIX), .AW(AW)) u_dec (
        .en  (any_hit),
        .idx (addr),
        .oh  (grant_oh)
    );

    assign served   = step && !slot_tick && (state_q == ST_SERVE);
    assign last_one = (grant_oh == svc_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (slot_tick && |req) state_d = ST_SERVE;
            end
            ST_SERVE: begin
                if (slot_tick)                state_d = |req ? ST_SERVE : ST_IDLE;
                else if (served && last_one)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= '0;
            ack_q <= '0;
        end else if (slot_tick) begin
            svc_q <= req;
            ack_q <= '0;
        end else if (served) begin
            svc_q <= svc_q & ~grant_oh;
            ack_q <= grant_oh;
        end else begin
            ack_q <= '0;
        end
    end

    assign ack = ack_q;
endmodule

// File: rtl/pixq_chk.sv
`timescale 1ns/1ps
module pixq_chk #(
    parameter int N  = 256,
    parameter int AW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_tick,
    input logic          step,
    input logic          any_hit,
    input logic [AW-1:0] addr,
    input logic [N-1:0]  ack
);
    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    p_ack_hits_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !slot_tick && any_hit) |=> ack[$past(addr)]);

    p_addr_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !slot_tick && any_hit) |=> (!any_hit || addr > $past(addr)));

    p_ack_needs_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && !slot_tick && any_hit) |=> (ack == '0));

    p_tick_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> (ack == '0));

    p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (addr == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !slot_tick) |=> ($stable(addr) && $stable(any_hit)));
endmodule

bind pixq_encoder pixq_chk #(.N(NPIX), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_tick (slot_tick),
    .step      (step),
    .any_hit   (any_hit),
    .addr      (addr),
    .ack       (ack)
);

// File: tb/tb_pixq_encoder.sv
`timescale 1ns/1ps
module tb_pixq_encoder;
    localparam int N  = 256;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          slot_tick = 1'b0;
    logic          step = 1'b0;
    logic          any_hit;
    logic [AW-1:0] addr;
    logic [N-1:0]  ack;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [N-1:0] m_set = '0;

    pixq_encoder #(.NPIX(N)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .slot_tick(slot_tick),
        .step(step), .any_hit(any_hit), .addr(addr), .ack(ack)
    );

    always #10 clk = ~clk;

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int lowest(input logic [N-1:0] v);
        int r = 0;
        for (int i = N - 1; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [N-1:0] bits2(input int a, input int b);
        logic [N-1:0] v = '0;
        v[a] = 1'b1;
        v[b] = 1'b1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%s expected=%s", tag, what, act, exp);
        end
    endtask

    // One clock with the given inputs, model update, then compare all outputs.
    task automatic cyc(input logic t, input logic s, input logic [N-1:0] r,
                       input string tag);
        logic [N-1:0] e_ack = '0;
        int lo;
        slot_tick = t; step = s; req = r;
        @(posedge clk); #1;
        if (t) m_set = r;
        else if (s && |m_set) begin
            lo = lowest(m_set);
            e_ack[lo] = 1'b1;
            m_set[lo] = 1'b0;
        end
        slot_tick = 1'b0; step = 1'b0;
        chk(any_hit == |m_set, tag, "any_hit",
            $sformatf("%0b", any_hit), $sformatf("%0b", |m_set));
        chk(addr == AW'(lowest(m_set)), tag, "addr",
            $sformatf("%0d", addr), $sformatf("%0d", lowest(m_set)));
        chk(ack == e_ack, tag, "ack",
            $sformatf("%h", ack), $sformatf("%h", e_ack));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_set = '0;
        chk(any_hit == 1'b0 && addr == '0 && ack == '0, "R7", "reset outputs",
            $sformatf("%0b/%0d/%h", any_hit, addr, ack), "0/0/0");
        rst_n = 1'b1;
        cyc(0, 0, '0, "R7");
    endtask

    task automatic t_basic();
        cyc(1, 0, bits2(2, 13), "R1");   // load pixels 2 and 13
        cyc(0, 1, bits2(2, 13), "R4");   // serve 2, present 13
        cyc(0, 1, bits2(2, 13), "R4");   // serve 13, empty
        cyc(0, 1, '0, "R5");             // step on empty set
        cyc(0, 0, '0, "R2");
    endtask

    task automatic t_hold();
        cyc(1, 0, bits2(5, 9), "R1");
        for (int i = 0; i < 3; i++) cyc(0, 0, '0, "R8");
        cyc(0, 1, '0, "R4");
        cyc(0, 1, '0, "R4");
    endtask

    task automatic t_late();
        logic [N-1:0] v = '0;
        v[40] = 1'b1;
        cyc(1, 0, v, "R3");
        v[3] = 1'b1;                     // arrives between boundaries
        cyc(0, 0, v, "R3");
        cyc(0, 1, v, "R3");              // only 40 is served
        cyc(0, 0, v, "R3");
        cyc(1, 0, v, "R3");              // next boundary picks up 3
        cyc(0, 1, '0, "R4");
        cyc(0, 1, '0, "R4");
    endtask

    task automatic t_edges();
        cyc(1, 0, bits2(0, 255), "R2");
        cyc(0, 1, '0, "R2");
        cyc(0, 1, '0, "R2");
        cyc(0, 1, '0, "R5");
    endtask

    task automatic t_collide();
        cyc(1, 0, bits2(7, 20), "R6");
        cyc(1, 1, bits2(1, 30), "R6");   // boundary and step together
        cyc(0, 1, '0, "R6");             // pixel 1 from the new slot
        cyc(0, 1, '0, "R4");
        cyc(1, 1, '0, "R6");             // boundary captures empty vector
    endtask

    task automatic t_dense();
        cyc(1, 0, '1, "R1");
        for (int i = 0; i < 4; i++) cyc(0, 1, '1, "R4");
        cyc(1, 0, '0, "R1");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_hold();
        t_late();
        t_edges();
        t_collide();
        t_dense();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule